// File: doc/BRIEF.md
# In-band Target Reset Detector

This block sits behind the synchronizers of a bus target and looks for the in-band reset sequence. The data line is held low while the clock line completes at least fourteen pulses, then a repeated START follows, then a STOP. When the whole sequence has been seen, the block gives a single-cycle request together with the reset action that was stored beforehand.

The action is written by a load strobe from the command decoder, which sits outside this block. Loading an action never causes a reset by itself. The stored action is one-shot. A START that is not the repeated START of the sequence discards it, and a completed sequence uses it up. In both cases the register falls back to the default peripheral-reset code. Carrying out the reset is left to the logic that receives the strobe.

Top module: `inband_rst_det`

## Requirements
- R1: One strobe on `rst_req_o` is produced for each sequence of this form: at least 14 SCL rising edges while SDA stays low, then a START (SDA falling while SCL is high), then a STOP (SDA rising while SCL is high).
- R2: `rst_req_o` is high for exactly one clock cycle. It rises on the third rising clock edge after the STOP first appears at the pins, because of the two synchronizer stages and one register. In that cycle `rst_act_o` carries the action that was stored, and it keeps that value until the next strobe.
- R3: A pulse on `act_load_i` stores `act_code_i` and produces no strobe.
- R4: A START seen while the block is not waiting for the repeated START of the sequence returns the stored action to the default 8'h01.
- R5: With no action stored, the sequence reports 8'h01. After every strobe the stored action returns to 8'h01.
- R6: SCL pulses beyond the fourteenth while SDA is still low keep the sequence valid.
- R7: If SDA goes high before the fourteenth SCL rising edge, the count is lost, and counting restarts from zero once SDA is low again. Thirteen pulses followed by a repeated START and a STOP give no strobe.
- R8: A STOP after the pulses but without a repeated START gives no strobe and leaves the stored action unchanged. An SCL rising edge between the repeated START and the STOP cancels the sequence, gives no strobe and leaves the stored action unchanged.
- R9: If a load falls in the same cycle as a strobe, the strobe reports the old action and the new code is kept for the next sequence. If a load falls in the same cycle as a clearing START, the load wins.
- R10: After reset, `rst_req_o` is 0, `rst_act_o` is 8'h01 and the stored action is 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| act_load_i | input | 1 | Strobe that stores `act_code_i` as the pending action |
| act_code_i | input | 8 | Action code to store |
| rst_req_o | output | 1 | Single-cycle reset request |
| rst_act_o | output | 8 | Action code that goes with the request |

## Verification
Two events can land on the same clock edge: the action load from the command decoder, and either a completed sequence or a START that clears the action. The bench first drives the STOP, or the clearing START, on the bus pins. It then raises the load exactly two clock cycles later, which is the cycle in which the synchronized condition reaches the control logic. It judges the outcome at the ports. For the STOP case, the strobe in that cycle must carry the old code and the next full sequence must carry the new one. For the START case, the next sequence must report the loaded code and not the default.

// File: rtl/irst_pkg.sv
package irst_pkg;
  localparam int ACT_W = 8;
  localparam logic [ACT_W-1:0] ACT_DEFAULT = 8'h01;
  localparam int NPULSE = 14;

  typedef enum logic [1:0] {
    ST_CNT,
    ST_ARMED,
    ST_WAIT_P
  } irst_st_e;
endpackage

// File: rtl/irst_sync.sv
module irst_sync #(
  parameter int N = 2,
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) st_q[i] <= '1;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < N; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[N-1];
endmodule

// File: rtl/irst_cond.sv
module irst_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // conditions need SCL high on both samples around the SDA edge
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
endmodule

// File: rtl/irst_fsm.sv
module irst_fsm
  import irst_pkg::*;
#(
  parameter int NPULSE_P = NPULSE,
  localparam int CW = $clog2(NPULSE_P + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          scl_rise_i,
  output logic          fire_o,
  output logic          clr_o,
  output logic [CW-1:0] cnt_o
);
  irst_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    fire_o = 1'b0;
    unique case (st_q)
      ST_CNT: begin
        if (sda_i) begin
          cnt_d = '0;
        end else if (scl_rise_i) begin
          if (cnt_q == CW'(NPULSE_P - 1)) begin
            cnt_d = CW'(NPULSE_P);
            st_d  = ST_ARMED;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_ARMED: begin
        // extra pulses with SDA low are ignored here
        if (stop_i) begin
          st_d  = ST_CNT;
          cnt_d = '0;
        end else if (start_i) begin
          st_d = ST_WAIT_P;
        end
      end
      ST_WAIT_P: begin
        if (stop_i) begin
          fire_o = 1'b1;
          st_d   = ST_CNT;
          cnt_d  = '0;
        end else if (scl_rise_i || start_i) begin
          st_d  = ST_CNT;
          cnt_d = '0;
        end
      end
      default: begin
        st_d  = ST_CNT;
        cnt_d = '0;
      end
    endcase
  end

  assign clr_o = start_i && (st_q != ST_ARMED);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_CNT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/inband_rst_det.sv
module inband_rst_det
  import irst_pkg::*;
#(
  parameter int               SYNC_N   = 2,
  parameter int               NPULSE_P = NPULSE,
  parameter logic [ACT_W-1:0] DEF_ACT  = ACT_DEFAULT,
  localparam int              CW       = $clog2(NPULSE_P + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             act_load_i,
  input  logic [ACT_W-1:0] act_code_i,
  output logic             rst_req_o,
  output logic [ACT_W-1:0] rst_act_o
);
  logic [1:0] bus_s;
  logic start_det, stop_det, scl_rise;
  logic fire, clr;
  logic [CW-1:0] cnt;
  logic [ACT_W-1:0] act_q, code_q;
  logic req_q;

  irst_sync #(.N(SYNC_N), .W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  irst_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (bus_s[1]),
    .sda_i     (bus_s[0]),
    .start_o   (start_det),
    .stop_o    (stop_det),
    .scl_rise_o(scl_rise)
  );

  irst_fsm #(.NPULSE_P(NPULSE_P)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (bus_s[0]),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .scl_rise_i(scl_rise),
    .fire_o    (fire),
    .clr_o     (clr),
    .cnt_o     (cnt)
  );

  // load has priority over consume/clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= DEF_ACT;
      code_q <= DEF_ACT;
      req_q  <= 1'b0;
    end else begin
      if (act_load_i)      act_q <= act_code_i;
      else if (fire || clr) act_q <= DEF_ACT;
      req_q <= fire;
      if (fire) code_q <= act_q;
    end
  end

  assign rst_req_o = req_q;
  assign rst_act_o = code_q;
endmodule

// File: rtl/irst_chk.sv
module irst_chk #(
  parameter int               ACT_W    = 8,
  parameter logic [ACT_W-1:0] DEF_ACT  = 8'h01,
  parameter int               NPULSE_P = 14,
  parameter int               CW       = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             act_load_i,
  input logic [ACT_W-1:0] act_code_i,
  input logic             rst_req_o,
  input logic [ACT_W-1:0] act_q,
  input logic             stop_det,
  input logic [CW-1:0]    cnt
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R2
  AST_REQ_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(stop_det)); // R1
  AST_LOAD_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_load_i |=> (act_q == $past(act_code_i))); // R3
  AST_DEFAULT_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !$past(act_load_i)) |-> (act_q == DEF_ACT)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(NPULSE_P)); // R6
endmodule

bind inband_rst_det irst_chk #(
  .ACT_W(irst_pkg::ACT_W), .DEF_ACT(DEF_ACT), .NPULSE_P(NPULSE_P), .CW(CW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .act_load_i(act_load_i),
  .act_code_i(act_code_i),
  .rst_req_o (rst_req_o),
  .act_q     (act_q),
  .stop_det  (stop_det),
  .cnt       (cnt)
);

// File: tb/inband_rst_det_tb.sv
module inband_rst_det_tb_top;
  localparam int CLK_P = 10;
  localparam int HOLD  = 4;

  typedef struct packed {
    logic       ld;
    logic [7:0] code;
    logic [2:0] kind;
    logic       hit;
    logic [7:0] exp_code;
  } vec_t;

  // kind: 0 full, 1 thirteen pulses, 2 abort then full, 3 sixteen pulses,
  //       4 normal START first, 5 STOP without Sr, 6 SCL pulse after Sr
  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 8'hA5, 3'd0, 1'b1, 8'hA5},
    '{1'b0, 8'h00, 3'd0, 1'b1, 8'h01},
    '{1'b1, 8'h3C, 3'd4, 1'b1, 8'h01},
    '{1'b1, 8'h77, 3'd1, 1'b0, 8'h00},
    '{1'b1, 8'h42, 3'd3, 1'b1, 8'h42},
    '{1'b1, 8'h19, 3'd2, 1'b1, 8'h19},
    '{1'b1, 8'h5A, 3'd5, 1'b0, 8'h00},
    '{1'b0, 8'h00, 3'd0, 1'b1, 8'h5A},
    '{1'b1, 8'h66, 3'd6, 1'b0, 8'h00},
    '{1'b0, 8'h00, 3'd0, 1'b1, 8'h66}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, ld = 1'b0;
  logic [7:0] code = 8'h00;
  logic req;
  logic [7:0] act;

  int n_chk = 0, n_bad = 0, hits = 0;
  logic [7:0] last_code = 8'h00;
  logic prev_req = 1'b0;
  bit done = 1'b0;

  inband_rst_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .act_load_i(ld), .act_code_i(code), .rst_req_o(req), .rst_act_o(act)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (req) begin
        hits++;
        last_code = act;
        if (prev_req) chk(1'b0, "R2 strobe longer than one cycle", 2, 1);
      end
      prev_req = req;
    end
  end

  task automatic set_bus(input logic s, input logic d);
    @(negedge clk);
    scl = s; sda = d;
    repeat (HOLD-1) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] c);
    @(negedge clk); ld = 1'b1; code = c;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic pulses(input int n);
    set_bus(1'b0, 1'b1);
    set_bus(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      set_bus(1'b1, 1'b0);
      set_bus(1'b0, 1'b0);
    end
  endtask

  task automatic rep_start();
    set_bus(1'b0, 1'b1);
    set_bus(1'b1, 1'b1);
    set_bus(1'b1, 1'b0);
  endtask

  task automatic run_kind(input logic [2:0] k);
    case (k)
      3'd1: begin pulses(13); rep_start(); set_bus(1'b1, 1'b1); end
      3'd2: begin
        pulses(5); set_bus(1'b0, 1'b1);
        pulses(14); rep_start(); set_bus(1'b1, 1'b1);
      end
      3'd3: begin pulses(16); rep_start(); set_bus(1'b1, 1'b1); end
      3'd4: begin
        set_bus(1'b1, 1'b0); set_bus(1'b1, 1'b1);
        pulses(14); rep_start(); set_bus(1'b1, 1'b1);
      end
      3'd5: begin pulses(14); set_bus(1'b1, 1'b0); set_bus(1'b1, 1'b1); end
      3'd6: begin
        pulses(14); rep_start();
        set_bus(1'b0, 1'b0); set_bus(1'b1, 1'b0); set_bus(1'b1, 1'b1);
      end
      default: begin pulses(14); rep_start(); set_bus(1'b1, 1'b1); end
    endcase
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R10 req in reset", int'(req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R10 req after reset", int'(req), 0);
    chk(act == 8'h01, "R10 code after reset", int'(act), 8'h01);

    // R3: load alone gives no strobe
    h0 = hits;
    load(8'hEE);
    repeat (10) @(negedge clk);
    chk(hits == h0, "R3 load causes no strobe", hits - h0, 0);
    set_bus(1'b1, 1'b0); set_bus(1'b1, 1'b1); // clearing START (R4)

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v].ld) load(VEC[v].code);
      h0 = hits;
      run_kind(VEC[v].kind);
      chk(hits - h0 == int'(VEC[v].hit), $sformatf("R1/R6/R7/R8 vec %0d strobes", v),
          hits - h0, int'(VEC[v].hit));
      if (VEC[v].hit)
        chk(last_code == VEC[v].exp_code, $sformatf("R4/R5 vec %0d code", v),
            int'(last_code), int'(VEC[v].exp_code));
    end

    // R9: load in the strobe cycle, R2 latency
    load(8'hB1);
    pulses(14); rep_start();
    @(negedge clk); scl = 1'b1; sda = 1'b1;
    @(negedge clk);
    @(negedge clk); ld = 1'b1; code = 8'hD4;
    @(negedge clk); ld = 1'b0;
    chk(req == 1'b1, "R2 strobe on third edge", int'(req), 1);
    chk(act == 8'hB1, "R9 strobe reports old code", int'(act), 8'hB1);
    @(negedge clk);
    chk(req == 1'b0, "R2 strobe one cycle", int'(req), 0);
    repeat (4) @(negedge clk);
    h0 = hits;
    run_kind(3'd0);
    chk(hits - h0 == 1, "R9 next sequence strobes", hits - h0, 1);
    chk(last_code == 8'hD4, "R9 new code kept", int'(last_code), 8'hD4);

    // R9: load in the clearing START cycle
    @(negedge clk); scl = 1'b1; sda = 1'b0;
    @(negedge clk);
    @(negedge clk); ld = 1'b1; code = 8'hC3;
    @(negedge clk); ld = 1'b0;
    repeat (3) @(negedge clk);
    set_bus(1'b1, 1'b1);
    h0 = hits;
    run_kind(3'd0);
    chk(hits - h0 == 1, "R9 sequence after START-load", hits - h0, 1);
    chk(last_code == 8'hC3, "R9 load beats clear", int'(last_code), 8'hC3);
    chk(act == 8'hC3, "R2 code held after strobe", int'(act), 8'hC3);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule